// File: doc/BRIEF.md
# DMA Channel Request Select and Suspend Control

This block sits inside one DMA channel and decides where its source-side and destination-side transaction requests come from. Each side has its own select input. With the select low, the side follows a hardware handshake line from a peripheral. With the select high, it follows a software request pulse, which is held until a transaction start uses it up. A side whose endpoint is memory needs no handshake, so its request is always present.

The block also lets software suspend a channel without losing data. While suspend is asserted, no new fetches from the source are started. Destination requests go on as usual, so the channel FIFO empties. A registered FIFO-empty flag reports when the drain has finished, and software can then disable the channel. The block takes the FIFO occupancy as an input and adds a back-pressure condition: it never enables a source fetch while the FIFO is full. The FIFO, the bus engine and the registers that hold the select and suspend bits are outside this block.

Top module: `dma_hs_ctrl`

## Requirements
- R1: With a side's select at 0 (hardware) and its memory flag at 0, that side's request output equals its hardware request input in the same cycle. A software pulse seen in hardware mode is not stored, so switching that side to software mode later does not raise a request.
- R2: With a side's select at 1 (software) and its memory flag at 0, that side's request output shows that side's stored software request and ignores the hardware request input.
- R3: A software pulse sampled at a clock edge while the select is 1 stores a pending request. A transaction-start input sampled at an edge clears it. When a pulse and a start arrive at the same edge, the pulse wins and the request stays pending.
- R4: While a side's memory flag is 1, that side's request output is 1, whatever its select, hardware line or pending state.
- R5: `src_fetch_en` is 1 exactly when the source request is 1, suspend is 0, and `fifo_level` is below the FIFO depth `DEPTH`.
- R6: Suspend has no effect on `dst_req`, so the FIFO can keep draining to the destination while the source is held.
- R7: `fifo_empty` is registered. After each edge it is 1 if `fifo_level` was 0 at that edge, and 0 otherwise.
- R8: While reset is asserted, both pending software requests clear and `fifo_empty` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_hw_req | input | 1 | Hardware handshake request from the source peripheral |
| dst_hw_req | input | 1 | Hardware handshake request from the destination peripheral |
| src_sw_pulse | input | 1 | Software request pulse, source side |
| dst_sw_pulse | input | 1 | Software request pulse, destination side |
| src_sel_sw | input | 1 | Source request select: 1 = software, 0 = hardware |
| dst_sel_sw | input | 1 | Destination request select: 1 = software, 0 = hardware |
| src_is_mem | input | 1 | Source endpoint is memory |
| dst_is_mem | input | 1 | Destination endpoint is memory |
| src_txn_start | input | 1 | A source transaction starts; uses up the pending software request |
| dst_txn_start | input | 1 | A destination transaction starts; uses up the pending software request |
| suspend | input | 1 | Hold new source fetches |
| fifo_level | input | LVL_W | Current channel FIFO occupancy, 0 to DEPTH |
| src_req | output | 1 | Effective source request |
| dst_req | output | 1 | Effective destination request |
| src_fetch_en | output | 1 | Permission to start a source fetch |
| fifo_empty | output | 1 | Registered FIFO-empty status |

## Verification
The assertions assume that `fifo_level` never goes above `DEPTH` and that the select, memory, pulse and start inputs are synchronous levels sampled at the rising edge. The bench changes every input on the falling edge and keeps `fifo_level` in the range 0 to `DEPTH`. It walks through every combination of the select, memory, hardware, pulse, start and suspend bits for both sides, with the occupancy rotating through all legal values. This covers pulses that arrive in hardware mode and pulses that arrive on the same edge as a start.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  // direction indices for the per-side request path array
  localparam int unsigned SIDE_SRC = 0;
  localparam int unsigned SIDE_DST = 1;
  localparam int unsigned N_SIDES  = 2;

  // per-side handshake controls, all sampled at the rising edge
  typedef struct packed {
    logic hw_req;
    logic sw_pulse;
    logic sel_sw;
    logic is_mem;
    logic txn_start;
  } side_ctl_t;
endpackage

// File: rtl/dma_hs_req_path.sv
module dma_hs_req_path
  import dma_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  side_ctl_t ctl,
  output logic      req
);
  logic pend_q;

  // pulse accepted only in software mode; pulse beats start on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n)                        pend_q <= 1'b0;
    else if (ctl.sel_sw && ctl.sw_pulse) pend_q <= 1'b1;
    else if (ctl.txn_start)            pend_q <= 1'b0;
  end

  always_comb begin
    if (ctl.is_mem)      req = 1'b1;
    else if (ctl.sel_sw) req = pend_q;
    else                 req = ctl.hw_req;
  end

  AST_SW_RISE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req) && ctl.sel_sw && !ctl.is_mem && $past(ctl.sel_sw) && !$past(ctl.is_mem))
      |-> $past(ctl.sw_pulse)) else $error("sw request rose without pulse"); // R2
  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel_sw && ctl.sw_pulse) |=> (req || !ctl.sel_sw))
    else $error("pulse not latched"); // R3
  AST_MEM_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.is_mem |-> req) else $error("memory side not ready"); // R4
endmodule

// File: rtl/dma_hs_fifo_status.sv
module dma_hs_fifo_status #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (!rst_n) empty <= 1'b1;
    else        empty <= (level == '0);
  end

  assign full = (32'(level) >= DEPTH);

  AST_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> empty) else $error("empty not set"); // R7
  AST_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |=> !empty) else $error("empty not cleared"); // R7
endmodule

// File: rtl/dma_hs_fetch_gate.sv
module dma_hs_fetch_gate (
  input  logic src_req,
  input  logic suspend,
  input  logic fifo_full,
  output logic fetch_en
);
  assign fetch_en = src_req && !suspend && !fifo_full;
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_hw_req,
  input  logic             dst_hw_req,
  input  logic             src_sw_pulse,
  input  logic             dst_sw_pulse,
  input  logic             src_sel_sw,
  input  logic             dst_sel_sw,
  input  logic             src_is_mem,
  input  logic             dst_is_mem,
  input  logic             src_txn_start,
  input  logic             dst_txn_start,
  input  logic             suspend,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             src_req,
  output logic             dst_req,
  output logic             src_fetch_en,
  output logic             fifo_empty
);
  side_ctl_t        side_ctl [N_SIDES];
  logic [N_SIDES-1:0] side_req;
  logic             fifo_full;

  assign side_ctl[SIDE_SRC] = '{hw_req: src_hw_req, sw_pulse: src_sw_pulse,
                                sel_sw: src_sel_sw, is_mem: src_is_mem,
                                txn_start: src_txn_start};
  assign side_ctl[SIDE_DST] = '{hw_req: dst_hw_req, sw_pulse: dst_sw_pulse,
                                sel_sw: dst_sel_sw, is_mem: dst_is_mem,
                                txn_start: dst_txn_start};

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    dma_hs_req_path u_path (
      .clk (clk),
      .rst_n (rst_n),
      .ctl (side_ctl[s]),
      .req (side_req[s])
    );
  end

  assign src_req = side_req[SIDE_SRC];
  assign dst_req = side_req[SIDE_DST];

  dma_hs_fifo_status #(.DEPTH(DEPTH)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .level (fifo_level),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  dma_hs_fetch_gate u_gate (
    .src_req   (src_req),
    .suspend   (suspend),
    .fifo_full (fifo_full),
    .fetch_en  (src_fetch_en)
  );

  AST_NO_FETCH_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> !src_fetch_en) else $error("fetch while suspended"); // R5
  AST_NO_FETCH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_level) >= DEPTH) |-> !src_fetch_en) else $error("fetch into full fifo"); // R5
  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_level) <= DEPTH) else $error("level out of range"); // R5
  AST_DST_SUSPEND_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_is_mem || (!dst_sel_sw && dst_hw_req)) |-> dst_req) else $error("dst blocked"); // R6
endmodule

// File: tb/test_dma_hs_ctrl.sv
module test_dma_hs_ctrl;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_hw = 0, d_hw = 0, s_pl = 0, d_pl = 0, s_sel = 1, d_sel = 1;
  logic s_mem = 0, d_mem = 0, s_st = 0, d_st = 0, susp = 0;
  logic [LVL_W-1:0] lvl = '0;
  logic src_req, dst_req, src_fetch_en, fifo_empty;

  int n_chk = 0;
  int n_fail = 0;
  bit m_spend, m_dpend, m_empty;

  always #2 clk = ~clk;  // 250 MHz

  dma_hs_ctrl #(.DEPTH(DEPTH)) i_dma_hs_ctrl (
    .clk(clk), .rst_n(rst_n),
    .src_hw_req(s_hw), .dst_hw_req(d_hw),
    .src_sw_pulse(s_pl), .dst_sw_pulse(d_pl),
    .src_sel_sw(s_sel), .dst_sel_sw(d_sel),
    .src_is_mem(s_mem), .dst_is_mem(d_mem),
    .src_txn_start(s_st), .dst_txn_start(d_st),
    .suspend(susp), .fifo_level(lvl),
    .src_req(src_req), .dst_req(dst_req),
    .src_fetch_en(src_fetch_en), .fifo_empty(fifo_empty)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_req(bit mem, bit sel, bit hw, bit pend);
    if (mem) return 1'b1;  // R4
    if (sel) return pend;  // R2
    return hw;             // R1
  endfunction

  initial begin : watchdog
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // pulses during reset must not stick (R8)
    s_pl = 1; d_pl = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 src pend", src_req, 1'b0);
    check("R8 dst pend", dst_req, 1'b0);
    check("R8 empty", fifo_empty, 1'b1);
    s_pl = 0; d_pl = 0;
    rst_n = 1;
    m_spend = 0; m_dpend = 0; m_empty = 1;
    @(negedge clk);
    check("R8 pend after reset", src_req | dst_req, 1'b0);

    for (int i = 0; i < 4096; i++) begin
      bit es, ed;
      @(negedge clk);
      {susp, d_hw, s_hw, d_st, d_pl, d_mem, d_sel, s_st, s_pl, s_mem, s_sel} = 11'(i ^ (i >> 5));
      lvl = LVL_W'((i * 7 + i / 11) % (DEPTH + 1));
      #1;
      es = exp_req(s_mem, s_sel, s_hw, m_spend);
      ed = exp_req(d_mem, d_sel, d_hw, m_dpend);
      check(s_mem ? "R4 src" : (s_sel ? "R2 src" : "R1 src"), src_req, es);
      check(d_susp_tag(), dst_req, ed);
      check("R5 fetch", src_fetch_en, es && !susp && (32'(lvl) < DEPTH));
      check("R7 empty", fifo_empty, m_empty);
      @(posedge clk);
      // R3 model: pulse in sw mode wins over start
      if (s_sel && s_pl) m_spend = 1; else if (s_st) m_spend = 0;
      if (d_sel && d_pl) m_dpend = 1; else if (d_st) m_dpend = 0;
      m_empty = (lvl == '0);
    end

    // R1: pulse in hw mode not stored, then switch to sw mode
    @(negedge clk);
    s_mem = 0; s_sel = 1; s_pl = 0; s_st = 1; susp = 0; lvl = '0;
    @(negedge clk);
    s_sel = 0; s_st = 0; s_pl = 1;
    @(negedge clk);
    s_pl = 0; s_sel = 1; s_hw = 1;
    #1 check("R1 hw-mode pulse dropped", src_req, 1'b0);
    // R3: same-edge pulse and start keeps pending
    s_pl = 1; s_st = 1;
    @(negedge clk);
    s_pl = 0; s_st = 0;
    #1 check("R3 pulse beats start", src_req, 1'b1);
    s_st = 1;
    @(negedge clk);
    s_st = 0;
    #1 check("R3 start clears", src_req, 1'b0);
    // R6: suspend with destination in hw mode, drain continues
    d_mem = 0; d_sel = 0; d_hw = 1; susp = 1; lvl = LVL_W'(2);
    #1 check("R6 dst under suspend", dst_req, 1'b1);
    check("R5 suspended fetch", src_fetch_en, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic string d_susp_tag();
    if (susp) return "R6 dst";
    return d_mem ? "R4 dst" : (d_sel ? "R2 dst" : "R1 dst");
  endfunction
endmodule